// File: doc/BRIEF.md
# Four-Channel PWM Generator with Committed Updates

This peripheral drives up to four independent pulse-width outputs from a single register bus. Each channel owns a 32-byte window of registers. A prescale divider slows the source clock into counting steps. A step counter runs through a modulus, and the channel output stays high while the step count is below a duty value.

Software stages a new prescale, modulus and duty through the bus. None of them reaches the output until the duty register is written. That write commits all three together. The committed set then waits for the running period to finish, so a period never mixes two settings. Clearing a channel's enable bit is the exception: the channel stops at once, and the next enable starts a fresh period from the latest committed set.

Reads are combinational and return the staged register contents. Any offset that maps to no register reads as zero.

Top module: `pwm_bank`

## Requirements
- R1: Channel c owns byte addresses c*32 to c*32+31. Within that window the prescale register sits at offset 0x00, the modulus at 0x04, the duty at 0x08, and the enable bit at bit 0 of offset 0x18.
- R2: A read returns the staged value zero-extended to 32 bits, with widths of 8 bits for prescale, 8 for modulus, 16 for duty and 1 for enable. Every other offset reads 0.
- R3: While enabled, one period lasts (prescale+1) × max(modulus,1) clock cycles. A modulus of 0 acts as 1, and the step counter never reaches the effective modulus.
- R4: Writing the prescale or the modulus register on its own leaves the channel output unchanged.
- R5: A duty write commits the staged prescale and modulus together with the new duty. The running period completes with the old set, and the new set applies from the next period boundary.
- R6: Writing 0 to the enable bit drives the output low from the cycle after the write, without finishing the period.
- R7: Writing 1 to the enable bit of a stopped channel starts a period at step 0 in the cycle after the write, using the most recently committed set.
- R8: The output is high while the step count is below the duty value. A duty of 0 gives a constant low output, and a duty at or above the effective modulus gives a constant high output.
- R9: Channels count and switch independently of one another.
- R10: After reset, all registers read 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock for counters and registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle with it high |
| bus_addr | input | 7 | Byte address: channel in bits 6:5, offset in bits 4:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 4 | One pulse output per channel |

## Verification
The assertions check several properties on every cycle. The step counter must stay below the effective modulus. The active modulus and duty may change only at a period boundary or while a channel is stopped. Prescale and modulus writes must not touch the committed set. An enable-clear must silence the output on the next cycle. A zero duty must keep the line low, and unmapped offsets must read zero. Only the bench scenarios can show the timing that involves whole periods: the old period finishing before a committed change appears, a fresh period at re-enable, exact high and period cycle counts for random settings, and two channels running side by side with unrelated phases.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam logic [4:0] OFF_PRE  = 5'h00;
  localparam logic [4:0] OFF_MOD  = 5'h04;
  localparam logic [4:0] OFF_DUTY = 5'h08;
  localparam logic [4:0] OFF_EN   = 5'h18;

  typedef enum logic [2:0] {
    SEL_PRE,
    SEL_MOD,
    SEL_DUTY,
    SEL_EN,
    SEL_NONE
  } reg_kind_e;

  // Map an in-window byte offset to the register it names.
  function automatic reg_kind_e decode_off(input logic [4:0] off);
    case (off)
      OFF_PRE:  return SEL_PRE;
      OFF_MOD:  return SEL_MOD;
      OFF_DUTY: return SEL_DUTY;
      OFF_EN:   return SEL_EN;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Number of steps per period: a zero modulus counts as a single step.
  function automatic int unsigned steps_per_period(input int unsigned modulus);
    return (modulus == 0) ? 1 : modulus;
  endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pre,
  input  logic              wr_mod,
  input  logic              wr_duty,
  input  logic              wr_en,
  input  logic [DUTY_W-1:0] wdata,
  output logic [PRE_W-1:0]  stg_pre,
  output logic [MOD_W-1:0]  stg_mod,
  output logic [DUTY_W-1:0] stg_duty,
  output logic              en,
  output logic [PRE_W-1:0]  cmt_pre,
  output logic [MOD_W-1:0]  cmt_mod,
  output logic [DUTY_W-1:0] cmt_duty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_pre  <= '0;
      stg_mod  <= '0;
      stg_duty <= '0;
      en       <= 1'b0;
      cmt_pre  <= '0;
      cmt_mod  <= '0;
      cmt_duty <= '0;
    end else begin
      if (wr_pre) stg_pre <= wdata[PRE_W-1:0];
      if (wr_mod) stg_mod <= wdata[MOD_W-1:0];
      if (wr_en)  en      <= wdata[0];
      if (wr_duty) begin
        // The duty write is the commit point for the whole set.
        stg_duty <= wdata;
        cmt_duty <= wdata;
        cmt_pre  <= stg_pre;
        cmt_mod  <= stg_mod;
      end
    end
  end

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PRE_W-1:0]  cmt_pre,
  input  logic [MOD_W-1:0]  cmt_mod,
  input  logic [DUTY_W-1:0] cmt_duty,
  output logic [MOD_W-1:0]  step_o,
  output logic [MOD_W-1:0]  act_mod_o,
  output logic [DUTY_W-1:0] act_duty_o,
  output logic              period_end_o,
  output logic              pwm_o
);

  localparam int CMP_W = (DUTY_W > MOD_W) ? DUTY_W : MOD_W;

  logic [PRE_W-1:0]  pcnt, act_pre;
  logic [MOD_W-1:0]  scnt, act_mod;
  logic [DUTY_W-1:0] act_duty;
  logic [MOD_W:0]    step_next, mod_eff;
  logic              tick_end;

  assign tick_end     = (pcnt == act_pre);
  assign step_next    = {1'b0, scnt} + 1'b1;
  assign mod_eff      = (MOD_W+1)'(pwm_pkg::steps_per_period(32'(act_mod)));
  assign period_end_o = en && tick_end && (step_next >= mod_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      scnt     <= '0;
      act_pre  <= '0;
      act_mod  <= '0;
      act_duty <= '0;
    end else if (!en) begin
      // Stopped: counters parked, active set follows the committed one.
      pcnt     <= '0;
      scnt     <= '0;
      act_pre  <= cmt_pre;
      act_mod  <= cmt_mod;
      act_duty <= cmt_duty;
    end else if (tick_end) begin
      pcnt <= '0;
      if (period_end_o) begin
        scnt     <= '0;
        act_pre  <= cmt_pre;
        act_mod  <= cmt_mod;
        act_duty <= cmt_duty;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign pwm_o      = en && (CMP_W'(scnt) < CMP_W'(act_duty));
  assign step_o     = scnt;
  assign act_mod_o  = act_mod;
  assign act_duty_o = act_duty;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int PRE_W  = 8,
  parameter  int MOD_W  = 8,
  parameter  int DUTY_W = 16,
  parameter  int DATA_W = 32,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  logic [CH_W-1:0] ch_sel;
  reg_kind_e       kind;

  assign ch_sel = bus_addr[ADDR_W-1:5];
  assign kind   = decode_off(bus_addr[4:0]);

  // Per-channel state, named so the bound checker can observe it.
  logic [NCH-1:0][PRE_W-1:0]  stg_pre_q, cmt_pre_q;
  logic [NCH-1:0][MOD_W-1:0]  stg_mod_q, cmt_mod_q, act_mod_q, step_q;
  logic [NCH-1:0][DUTY_W-1:0] stg_duty_q, cmt_duty_q, act_duty_q;
  logic [NCH-1:0]             en_q, period_end;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DUTY_W];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = bus_we && (ch_sel == CH_W'(g));

    pwm_chan_regs #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_pre   (hit && kind == SEL_PRE),
      .wr_mod   (hit && kind == SEL_MOD),
      .wr_duty  (hit && kind == SEL_DUTY),
      .wr_en    (hit && kind == SEL_EN),
      .wdata    (bus_wdata[DUTY_W-1:0]),
      .stg_pre  (stg_pre_q[g]),
      .stg_mod  (stg_mod_q[g]),
      .stg_duty (stg_duty_q[g]),
      .en       (en_q[g]),
      .cmt_pre  (cmt_pre_q[g]),
      .cmt_mod  (cmt_mod_q[g]),
      .cmt_duty (cmt_duty_q[g])
    );

    pwm_chan_core #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en_q[g]),
      .cmt_pre      (cmt_pre_q[g]),
      .cmt_mod      (cmt_mod_q[g]),
      .cmt_duty     (cmt_duty_q[g]),
      .step_o       (step_q[g]),
      .act_mod_o    (act_mod_q[g]),
      .act_duty_o   (act_duty_q[g]),
      .period_end_o (period_end[g]),
      .pwm_o        (pwm_out[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(ch_sel) < NCH) begin
      case (kind)
        SEL_PRE:  bus_rdata = DATA_W'(stg_pre_q[ch_sel]);
        SEL_MOD:  bus_rdata = DATA_W'(stg_mod_q[ch_sel]);
        SEL_DUTY: bus_rdata = DATA_W'(stg_duty_q[ch_sel]);
        SEL_EN:   bus_rdata = DATA_W'(en_q[ch_sel]);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int PRE_W  = 8,
  parameter  int MOD_W  = 8,
  parameter  int DUTY_W = 16,
  parameter  int DATA_W = 32,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            en_q,
  input logic [NCH-1:0]            period_end,
  input logic [NCH-1:0][MOD_W-1:0] step_q,
  input logic [NCH-1:0][MOD_W-1:0] act_mod_q,
  input logic [NCH-1:0][DUTY_W-1:0] act_duty_q,
  input logic [NCH-1:0][MOD_W-1:0] cmt_mod_q,
  input logic [NCH-1:0][PRE_W-1:0] cmt_pre_q
);

  reg_kind_e kind_w;
  assign kind_w = decode_off(bus_addr[4:0]);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_w == SEL_NONE) |-> (bus_rdata == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic hit;
    assign hit = bus_we && (bus_addr[ADDR_W-1:5] == CH_W'(g));

    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[g] |-> (32'(step_q[g]) < steps_per_period(32'(act_mod_q[g]))));

    assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (kind_w == SEL_PRE || kind_w == SEL_MOD))
        |=> ($stable(cmt_mod_q[g]) && $stable(cmt_pre_q[g])));

    assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[g] && !period_end[g])
        |=> ($stable(act_mod_q[g]) && $stable(act_duty_q[g])));

    assert_stop_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && kind_w == SEL_EN && !bus_wdata[0]) |=> !pwm_out[g]);

    assert_zero_duty_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty_q[g] == '0) |-> !pwm_out[g]);
  end

endmodule

bind pwm_bank pwm_bank_chk #(
  .NCH(NCH), .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pwm_out    (pwm_out),
  .en_q       (en_q),
  .period_end (period_end),
  .step_q     (step_q),
  .act_mod_q  (act_mod_q),
  .act_duty_q (act_duty_q),
  .cmt_mod_q  (cmt_mod_q),
  .cmt_pre_q  (cmt_pre_q)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

  localparam logic [4:0] O_PRE = 5'h00, O_MOD = 5'h04, O_DUTY = 5'h08, O_EN = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pwm_bank i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic int eff(input int m);
    return (m == 0) ? 1 : m;
  endfunction
  function automatic int period_cyc(input int p, input int m);
    return (p + 1) * eff(m);
  endfunction
  function automatic int high_cyc(input int p, input int m, input int d);
    return (p + 1) * ((d < eff(m)) ? d : eff(m));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [4:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {2'(ch), off}; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [4:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = {2'(ch), off};
    #1 d = bus_rdata;
  endtask

  // Counts high samples over n cycles, starting at the current negedge.
  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out[ch]);
      @(negedge clk);
    end
  endtask

  task automatic setup(input int ch, input int p, input int m, input int d);
    wr(ch, O_PRE, 32'(p));
    wr(ch, O_MOD, 32'(m));
    wr(ch, O_DUTY, 32'(d));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int h, h0, h1, h2, ha, hb;
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk(pwm_out == 4'b0, "R10 outputs low", int'(pwm_out), 0);
    for (int c = 0; c < 4; c++) begin
      rd(c, O_DUTY, v); chk(v == 0, "R10 duty reset", int'(v), 0);
      rd(c, O_PRE, v);  chk(v == 0, "R10 prescale reset", int'(v), 0);
    end

    // R1: distinct values per channel and register read back from the right place
    for (int c = 0; c < 4; c++) begin
      wr(c, O_PRE, 32'(8'h10 + c)); wr(c, O_MOD, 32'(8'h20 + c)); wr(c, O_DUTY, 32'(16'h300 + c));
    end
    for (int c = 0; c < 4; c++) begin
      rd(c, O_PRE, v);  chk(v == 32'(8'h10 + c), "R1 prescale map", int'(v), 8'h10 + c);
      rd(c, O_MOD, v);  chk(v == 32'(8'h20 + c), "R1 modulus map", int'(v), 8'h20 + c);
      rd(c, O_DUTY, v); chk(v == 32'(16'h300 + c), "R1 duty map", int'(v), 16'h300 + c);
    end

    // R2: widths and unmapped offsets
    wr(2, O_PRE, 32'hFFFF_FFFF); wr(2, O_MOD, 32'hFFFF_FFFF); wr(2, O_DUTY, 32'hFFFF_FFFF);
    wr(2, O_EN, 32'hFFFF_FFFE);
    rd(2, O_PRE, v);  chk(v == 32'hFF, "R2 prescale width", int'(v), 255);
    rd(2, O_MOD, v);  chk(v == 32'hFF, "R2 modulus width", int'(v), 255);
    rd(2, O_DUTY, v); chk(v == 32'hFFFF, "R2 duty width", int'(v), 65535);
    rd(2, O_EN, v);   chk(v == 0, "R2 enable bit0 only", int'(v), 0);
    rd(2, 5'h0C, v);  chk(v == 0, "R2 unmapped 0x0C", int'(v), 0);
    rd(2, 5'h1C, v);  chk(v == 0, "R2 unmapped 0x1C", int'(v), 0);
    rd(2, 5'h01, v);  chk(v == 0, "R2 unmapped 0x01", int'(v), 0);

    // R3 R8: random settings, two consecutive periods measured from enable
    for (int it = 0; it < 10; it++) begin
      int c, p, m, d, pc, hc;
      c = int'($urandom % 4); p = int'($urandom % 4);
      m = int'($urandom % 12); d = int'($urandom % 16);
      pc = period_cyc(p, m); hc = high_cyc(p, m, d);
      setup(c, p, m, d);
      wr(c, O_EN, 1);
      count_high(c, pc, h0);
      count_high(c, pc, h1);
      chk(h0 == hc, "R3 first period high time", h0, hc);
      chk(h1 == hc, "R3 second period high time", h1, hc);
      wr(c, O_EN, 0);
    end

    // R8: constant levels
    setup(0, 0, 5, 0); wr(0, O_EN, 1); count_high(0, 20, h);
    chk(h == 0, "R8 zero duty low", h, 0);
    wr(0, O_EN, 0);
    setup(0, 0, 5, 9); wr(0, O_EN, 1); count_high(0, 20, h);
    chk(h == 20, "R8 duty above modulus high", h, 20);
    wr(0, O_EN, 0);
    setup(0, 2, 0, 1); wr(0, O_EN, 1); count_high(0, 12, h);
    chk(h == 12, "R3 zero modulus acts as one", h, 12);
    wr(0, O_EN, 0);

    // R4 R5: staged modulus, then duty commit mid-period
    setup(1, 1, 6, 2); wr(1, O_EN, 1);
    h0 = 0; h1 = 0; h2 = 0;
    for (int i = 0; i < 28; i++) begin
      if (i < 12) h0 += int'(pwm_out[1]);
      else if (i < 20) h1 += int'(pwm_out[1]);
      else h2 += int'(pwm_out[1]);
      if (i == 1) begin bus_we = 1; bus_addr = {2'd1, O_MOD}; bus_wdata = 4; end
      else if (i == 3) begin bus_we = 1; bus_addr = {2'd1, O_DUTY}; bus_wdata = 3; end
      else bus_we = 0;
      @(negedge clk);
    end
    chk(h0 == 4, "R5 running period keeps old set", h0, 4);
    chk(h1 == 6, "R5 new set from boundary", h1, 6);
    chk(h2 == 6, "R5 new set persists", h2, 6);
    rd(1, O_MOD, v); chk(v == 4, "R4 staged modulus reads back", int'(v), 4);
    wr(1, O_EN, 0);

    // R4 R5: prescale alone ignored until a duty write commits it
    setup(2, 0, 4, 2); wr(2, O_EN, 1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < 36; i++) begin
      if (i < 20) h0 += int'(pwm_out[2]);
      else h1 += int'(pwm_out[2]);
      if (i == 0) begin bus_we = 1; bus_addr = {2'd2, O_PRE}; bus_wdata = 3; end
      else if (i == 16) begin bus_we = 1; bus_addr = {2'd2, O_DUTY}; bus_wdata = 2; end
      else bus_we = 0;
      @(negedge clk);
    end
    chk(h0 == 10, "R4 prescale write alone no effect", h0, 10);
    chk(h1 == 8, "R5 prescale applies with commit", h1, 8);
    wr(2, O_EN, 0);

    // R6: immediate stop
    setup(3, 3, 10, 8); wr(3, O_EN, 1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < 30; i++) begin
      if (i == 5) h0 = int'(pwm_out[3]);
      if (i > 5) h1 += int'(pwm_out[3]);
      if (i == 5) begin bus_we = 1; bus_addr = {2'd3, O_EN}; bus_wdata = 0; end
      else bus_we = 0;
      @(negedge clk);
    end
    chk(h0 == 1, "R6 high before stop", h0, 1);
    chk(h1 == 0, "R6 low right after stop", h1, 0);
    rd(3, O_EN, v); chk(v == 0, "R6 enable reads 0", int'(v), 0);

    // R7: commit while stopped, enable starts fresh period with it
    wr(3, O_DUTY, 4); wr(3, O_EN, 1);
    chk(pwm_out[3] == 1'b1, "R7 first cycle high", int'(pwm_out[3]), 1);
    count_high(3, 40, h0); count_high(3, 40, h1);
    chk(h0 == 16, "R7 first period uses committed set", h0, 16);
    chk(h1 == 16, "R7 second period", h1, 16);
    wr(3, O_EN, 0);

    // R9: two channels at once with unrelated phase
    setup(0, 0, 4, 1); setup(3, 1, 3, 2);
    wr(0, O_EN, 1); wr(3, O_EN, 1);
    ha = 0; hb = 0;
    for (int i = 0; i < 24; i++) begin
      ha += int'(pwm_out[0]); hb += int'(pwm_out[3]);
      @(negedge clk);
    end
    chk(ha == 6, "R9 channel 0 alongside 3", ha, 6);
    chk(hb == 16, "R9 channel 3 alongside 0", hb, 16);
    chk(pwm_out[1] == 1'b0, "R9 idle channel stays low", int'(pwm_out[1]), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule